// File: doc/BRIEF.md
# Link Power State Controller

This block chooses the power state of a serial link for a bridge-type device. It combines the device power state written by software, the active-state enable field of the link control register, a separate override bit, an idle indication from the link, and an active-low wake pin from the downstream bus. From these it produces the target link state and a beacon request. The physical layer, the message exchanges with the upstream port, and power or clock removal are handled elsewhere. The block sees the result of those steps only as a power-restored acknowledge.

Software-directed states have priority. D1 and D2 put the link in L1. D3hot puts it in L2 when auxiliary power is present. When the device is in D0 and the link has been idle long enough, hardware can move the link into L0s or L1 on its own. Any traffic brings the link back to L0. When the link is in L2, a wake request on the downstream pin raises a beacon. The beacon stays up until power is restored upstream, and the link then returns to L0.

Top module: `link_pm_ctrl`

## Requirements
- R1: After reset the link state is L0 (code 0), the beacon is low, and the override bit is 1. Hardware entry therefore works without any configuration write.
- R2: In D1 (code 1) or D2 (code 2), the link state is L1 (code 2) at the next clock edge, unless the link is in L2.
- R3: In D3hot (code 3), the link goes to L2 (code 3) when aux_pwr_i is 1, and to L1 when it is 0.
- R4: Once in L2, the link stays in L2 whatever the device state, idle input or ASPM field. It leaves only through the wake sequence.
- R5: ASPM field encoding: bit 0 enables hardware entry into L0s (code 1) and bit 1 enables hardware entry into L1. 00 disables both, 01 enables L0s only, 10 enables L1 only, 11 enables both.
- R6: In D0, the state moves to L0s at the edge where the run of consecutive idle cycles reaches l0s_idle_i. It moves to L1 at the edge where the run reaches l1_idle_i, and the run keeps counting while in L0s. L1 wins when both thresholds are met.
- R7: In D0, link_idle_i = 0 returns the link to L0 at the next edge and restarts the idle run.
- R8: The override bit is bit 30 of the word written to address 0xC8. When it is 0, no hardware entry into L0s or L1 happens, and a link already in a hardware-entered L0s or L1 returns to L0. Writes to any other address leave the bit unchanged.
- R9: While in L2, wake_ni low raises beacon_o after a two-stage synchronizer: the beacon is high after the third edge and not after the second. Outside L2 the wake pin is ignored.
- R10: beacon_o stays high until pwr_ack_i. At that edge the beacon drops and the link goes to L0. pwr_ack_i has no effect while the beacon is low.
- R11: After a wake exit the link stays in L0 while the device state still reads D3hot. It can enter L2 again only after the device state has left D3hot.
- R12: Writing D0 while the link is in a device-driven L1 returns the link to L0 at the next edge, even if the link is idle and ASPM L1 entry is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dstate_i | input | 2 | Device power state: 0 D0, 1 D1, 2 D2, 3 D3hot |
| aspm_en_i | input | 2 | Active-state enable field from the link control register |
| aux_pwr_i | input | 1 | Auxiliary power present |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration write address |
| cfg_wdata_i | input | 32 | Configuration write data |
| link_idle_i | input | 1 | Link idle; 0 means traffic is pending |
| l0s_idle_i | input | 8 | Idle run that triggers L0s entry |
| l1_idle_i | input | 8 | Idle run that triggers L1 entry |
| wake_ni | input | 1 | Asynchronous active-low wake pin from the downstream bus |
| pwr_ack_i | input | 1 | Upstream power and clock restored |
| link_state_o | output | 2 | Target link state: 0 L0, 1 L0s, 2 L1, 3 L2 |
| beacon_o | output | 1 | Beacon request toward the upstream link |

## Verification
The assertions assume that the device state, the ASPM field, the thresholds and pwr_ack_i are synchronous to clk_i. They also assume that the upstream side raises pwr_ack_i only in answer to a beacon. The bench drives every input 2 ns after a rising edge and asserts pwr_ack_i only while the beacon is high, except in one deliberate check that the acknowledge is ignored. The wake pin is the only asynchronous input. The bench releases it and waits out the synchronizer depth before each L2 entry, so a stale wake cannot raise the beacon early. The thresholds are kept at 1 to 5, well below counter saturation. This allows the idle-run sweep to compute the expected state from the run length alone.

// File: rtl/link_pm_pkg.sv
package link_pm_pkg;
  typedef enum logic [1:0] {
    DEV_D0 = 2'd0,
    DEV_D1 = 2'd1,
    DEV_D2 = 2'd2,
    DEV_D3 = 2'd3
  } dev_state_e;

  typedef enum logic [1:0] {
    LNK_L0  = 2'd0,
    LNK_L0S = 2'd1,
    LNK_L1  = 2'd2,
    LNK_L2  = 2'd3
  } lnk_state_e;

  localparam int unsigned ASPM_L0S_BIT = 0;
  localparam int unsigned ASPM_L1_BIT  = 1;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= RESET_VAL;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {STAGES{RESET_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] OVR_ADDR = 8'hC8,
  parameter int unsigned OVR_BIT  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ovr_o
);
  localparam logic [DATA_W-1:0] OVR_MASK = DATA_W'(1) << OVR_BIT;

  logic ovr_q;
  logic unused_wbits;

  assign unused_wbits = ^(wdata_i & ~OVR_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b1;
    else if (we_i && addr_i == OVR_ADDR) ovr_q <= wdata_i[OVR_BIT];
  end

  assign ovr_o = ovr_q;
endmodule

// File: rtl/lpm_idle_cnt.sv
module lpm_idle_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             count_en_i,
  output logic [CNT_W-1:0] run_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // run including the current idle cycle, saturating
  assign run_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (idle_i && count_en_i) cnt_q <= run_o;
    else                         cnt_q <= '0;
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import link_pm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       dstate_i,
  input  logic [1:0]       aspm_en_i,
  input  logic             ovr_i,
  input  logic             aux_pwr_i,
  input  logic             link_idle_i,
  input  logic [CNT_W-1:0] run_i,
  input  logic [CNT_W-1:0] l0s_thr_i,
  input  logic [CNT_W-1:0] l1_thr_i,
  input  logic             wake_req_i,
  input  logic             pwr_ack_i,
  output lnk_state_e       state_o,
  output logic             beacon_o
);
  lnk_state_e st_q, st_d;
  logic bcn_q, bcn_d;
  logic dev_l1_q, dev_l1_d;   // L1 entered because of device state
  logic hold_q, hold_d;       // post-wake: block L2 re-entry while still D3

  logic hw_ok, l0s_hit, l1_hit;

  assign hw_ok   = ovr_i && (aspm_en_i != 2'b00);
  assign l0s_hit = aspm_en_i[ASPM_L0S_BIT] && (run_i >= l0s_thr_i);
  assign l1_hit  = aspm_en_i[ASPM_L1_BIT]  && (run_i >= l1_thr_i);

  always_comb begin
    st_d     = st_q;
    bcn_d    = bcn_q;
    dev_l1_d = dev_l1_q;
    hold_d   = hold_q;
    if (dev_state_e'(dstate_i) != DEV_D3) hold_d = 1'b0;

    if (st_q == LNK_L2) begin
      if (bcn_q && pwr_ack_i) begin
        st_d     = LNK_L0;
        bcn_d    = 1'b0;
        hold_d   = 1'b1;
        dev_l1_d = 1'b0;
      end else if (wake_req_i) begin
        bcn_d = 1'b1;
      end
    end else begin
      unique case (dev_state_e'(dstate_i))
        DEV_D1, DEV_D2: begin
          st_d     = LNK_L1;
          dev_l1_d = 1'b1;
        end
        DEV_D3: begin
          if (hold_q) begin
            st_d     = LNK_L0;
            dev_l1_d = 1'b0;
          end else if (aux_pwr_i) begin
            st_d     = LNK_L2;
            dev_l1_d = 1'b0;
          end else begin
            st_d     = LNK_L1;
            dev_l1_d = 1'b1;
          end
        end
        default: begin
          dev_l1_d = 1'b0;
          if (!link_idle_i || !hw_ok || dev_l1_q)     st_d = LNK_L0;
          else if (l1_hit)                             st_d = LNK_L1;
          else if (st_q == LNK_L1)
            st_d = aspm_en_i[ASPM_L1_BIT] ? LNK_L1 : LNK_L0;
          else if (l0s_hit)                            st_d = LNK_L0S;
          else                                         st_d = LNK_L0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= LNK_L0;
      bcn_q    <= 1'b0;
      dev_l1_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      bcn_q    <= bcn_d;
      dev_l1_q <= dev_l1_d;
      hold_q   <= hold_d;
    end
  end

  assign state_o  = st_q;
  assign beacon_o = bcn_q;
endmodule

// File: rtl/link_pm_ctrl.sv
module link_pm_ctrl
  import link_pm_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter logic [ADDR_W-1:0] OVR_ADDR = 8'hC8,
  parameter int unsigned OVR_BIT     = 30,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        dstate_i,
  input  logic [1:0]        aspm_en_i,
  input  logic              aux_pwr_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              link_idle_i,
  input  logic [CNT_W-1:0]  l0s_idle_i,
  input  logic [CNT_W-1:0]  l1_idle_i,
  input  logic              wake_ni,
  input  logic              pwr_ack_i,
  output logic [1:0]        link_state_o,
  output logic              beacon_o
);
  logic             aspm_ovr;
  logic             wake_n_sync;
  logic [CNT_W-1:0] idle_run;
  lnk_state_e       state;
  logic             count_en;

  lpm_cfg_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OVR_ADDR(OVR_ADDR), .OVR_BIT(OVR_BIT)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .ovr_o(aspm_ovr)
  );

  lpm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wake_sync (
    .clk_i, .rst_ni, .d_i(wake_ni), .q_o(wake_n_sync)
  );

  assign count_en = (state == LNK_L0) || (state == LNK_L0S);

  lpm_idle_cnt #(.CNT_W(CNT_W)) u_idle (
    .clk_i, .rst_ni, .idle_i(link_idle_i), .count_en_i(count_en), .run_o(idle_run)
  );

  lpm_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni,
    .dstate_i, .aspm_en_i, .ovr_i(aspm_ovr), .aux_pwr_i, .link_idle_i,
    .run_i(idle_run), .l0s_thr_i(l0s_idle_i), .l1_thr_i(l1_idle_i),
    .wake_req_i(!wake_n_sync), .pwr_ack_i,
    .state_o(state), .beacon_o
  );

  assign link_state_o = state;
endmodule

// File: rtl/link_pm_ctrl_chk.sv
module link_pm_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] dstate_i,
  input logic [1:0] aspm_en_i,
  input logic       link_idle_i,
  input logic       pwr_ack_i,
  input logic [1:0] link_state_o,
  input logic       beacon_o,
  input logic       aspm_ovr
);
  // R2
  dev_l1_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o != 2'd3 && (dstate_i == 2'd1 || dstate_i == 2'd2)) |=> link_state_o == 2'd2);

  // R4
  l2_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == 2'd3 && !(beacon_o && pwr_ack_i)) |=> link_state_o == 2'd3);

  // R5
  aspm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o != 2'd3 && dstate_i == 2'd0 && aspm_en_i == 2'b00) |=> link_state_o == 2'd0);

  // R7
  traffic_l0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o != 2'd3 && dstate_i == 2'd0 && !link_idle_i) |=> link_state_o == 2'd0);

  // R8
  ovr_veto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o != 2'd3 && dstate_i == 2'd0 && !aspm_ovr) |=> link_state_o == 2'd0);

  // R9
  beacon_in_l2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beacon_o |-> link_state_o == 2'd3);

  // R10
  beacon_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beacon_o && !pwr_ack_i) |=> beacon_o);

  // R10
  wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == 2'd3 && beacon_o && pwr_ack_i) |=> (link_state_o == 2'd0 && !beacon_o));
endmodule

bind link_pm_ctrl link_pm_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dstate_i(dstate_i), .aspm_en_i(aspm_en_i),
  .link_idle_i(link_idle_i), .pwr_ack_i(pwr_ack_i), .link_state_o(link_state_o),
  .beacon_o(beacon_o), .aspm_ovr(aspm_ovr)
);

// File: tb/link_pm_ctrl_test.sv
`timescale 1ns/1ps
module link_pm_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  dstate_i = 2'd0;
  logic [1:0]  aspm_en_i = 2'b00;
  logic        aux_pwr_i = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = 8'h00;
  logic [31:0] cfg_wdata_i = 32'h0;
  logic        link_idle_i = 1'b0;
  logic [7:0]  l0s_idle_i = 8'd2;
  logic [7:0]  l1_idle_i = 8'd4;
  logic        wake_ni = 1'b1;
  logic        pwr_ack_i = 1'b0;
  logic [1:0]  link_state_o;
  logic        beacon_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  link_pm_ctrl uut (.*);

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [31:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    tick();
    cfg_we_i = 1'b0;
  endtask

  function automatic int exp_state(int aspm, int ovr, int l0s, int l1, int k);
    if (ovr == 0) return 0;
    if ((aspm & 2) != 0 && k >= l1) return 2;
    if ((aspm & 1) != 0 && k >= l0s) return 1;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1 state", link_state_o, 0);
    chk("R1 beacon", beacon_o, 0);
    // R1 override defaults to 1: L0s entry works with no config write
    aspm_en_i = 2'b01; l0s_idle_i = 8'd2; link_idle_i = 1'b1;
    tick();
    chk("R1 run1", link_state_o, 0);
    tick();
    chk("R1 ovr default", link_state_o, 1);
    link_idle_i = 1'b0;
    tick();
    chk("R7 traffic exit", link_state_o, 0);

    // R5 R6 R8 R7 sweep
    for (int ovr = 0; ovr < 2; ovr++) begin
      cfg_write(8'hC8, 32'(ovr) << 30);
      for (int aspm = 0; aspm < 4; aspm++) begin
        for (int l0s = 1; l0s <= 3; l0s++) begin
          for (int l1 = l0s; l1 <= l0s + 2; l1++) begin
            aspm_en_i = 2'(aspm); l0s_idle_i = 8'(l0s); l1_idle_i = 8'(l1);
            link_idle_i = 1'b0;
            tick();
            chk("R7 start L0", link_state_o, 0);
            link_idle_i = 1'b1;
            for (int k = 1; k <= 7; k++) begin
              tick();
              chk("R5/R6/R8 idle run", link_state_o, exp_state(aspm, ovr, l0s, l1, k));
            end
            link_idle_i = 1'b0;
            tick();
            chk("R7 traffic", link_state_o, 0);
          end
        end
      end
    end

    // R8 write to other address ignored (override stays 1)
    aspm_en_i = 2'b01; l0s_idle_i = 8'd2; l1_idle_i = 8'd4;
    cfg_write(8'hC4, 32'h0);
    link_idle_i = 1'b1;
    tick(2);
    chk("R8 other addr ignored", link_state_o, 1);
    // R8 clearing override while in L0s returns L0
    cfg_write(8'hC8, 32'h0);
    tick();
    chk("R8 clear in L0s", link_state_o, 0);
    cfg_write(8'hC8, 32'h4000_0000);
    link_idle_i = 1'b0;
    tick();

    // R2 R12
    aspm_en_i = 2'b11; link_idle_i = 1'b1;
    dstate_i = 2'd1;
    tick();
    chk("R2 D1", link_state_o, 2);
    dstate_i = 2'd0;
    tick();
    chk("R12 D0 from dev L1", link_state_o, 0);
    dstate_i = 2'd2;
    tick();
    chk("R2 D2", link_state_o, 2);
    dstate_i = 2'd0; link_idle_i = 1'b0;
    tick();

    // R3 no aux
    aux_pwr_i = 1'b0; dstate_i = 2'd3;
    tick();
    chk("R3 D3 no aux", link_state_o, 2);
    dstate_i = 2'd0;
    tick();

    // R9 wake ignored outside L2
    wake_ni = 1'b0;
    tick(4);
    chk("R9 wake ignored in L0", beacon_o, 0);
    wake_ni = 1'b1;
    tick(3);

    // R3 D3 with aux
    aux_pwr_i = 1'b1; dstate_i = 2'd3;
    tick();
    chk("R3 D3 aux", link_state_o, 3);
    // R4 L2 sticky
    dstate_i = 2'd0; link_idle_i = 1'b0;
    tick(3);
    chk("R4 L2 held", link_state_o, 3);
    dstate_i = 2'd3;
    // R10 ack without beacon ignored
    pwr_ack_i = 1'b1;
    tick();
    chk("R10 ack ignored", link_state_o, 3);
    pwr_ack_i = 1'b0;
    // R9 latency
    wake_ni = 1'b0;
    tick(2);
    chk("R9 beacon after 2", beacon_o, 0);
    tick();
    chk("R9 beacon after 3", beacon_o, 1);
    wake_ni = 1'b1;
    tick(4);
    chk("R10 beacon held", beacon_o, 1);
    chk("R10 still L2", link_state_o, 3);
    pwr_ack_i = 1'b1;
    tick();
    pwr_ack_i = 1'b0;
    chk("R10 exit L0", link_state_o, 0);
    chk("R10 beacon drop", beacon_o, 0);
    // R11 hold in D3
    tick(3);
    chk("R11 no L2 reentry", link_state_o, 0);
    dstate_i = 2'd0;
    tick();
    chk("R11 D0", link_state_o, 0);
    dstate_i = 2'd3;
    tick();
    chk("R11 reentry after leave", link_state_o, 3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule